// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-mapped command front end of an SD card host controller. Software on a 32-bit register bus loads an argument word and then writes a command word whose top bit starts a transaction. The unit passes the command index, flags and argument to a card command engine through a one-cycle start strobe. It then waits for that engine to report completion, a CRC7 error, or the end of the card's busy period.

The unit keeps the last response in four 32-bit words. It keeps a host status register whose error and event bits software clears by writing ones, and a programmable timeout count that bounds the wait for a response. The enable bit of the command word clears itself when the command has been handled, so software can poll it. A command that fails also sets a sticky failed bit in the command word. Serialising the CMD line, CRC generation and the data path are handled elsewhere. The data path reports only its events into the status register.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset the command and argument words read 0, the timeout word reads 0x00F00000, all four response words read 0 and host status reads 0.
- R2: The command word (offset 0x00) holds the index in bits 5:0, read-data in bit 6, write-data in bit 7, long response in bit 9, no response in bit 10, busy wait in bit 11, failed in bit 14 and enable in bit 15. Bits 8, 12 and 13 read 0, and software cannot set bit 14. An accepted write with bit 15 set gives a one-cycle `eng_start_o` in the following cycle. That cycle also carries the index, the argument (offset 0x04) and `eng_flags_o` = {busy, no-response, long, write, read} (bit 4 down to bit 0).
- R3: Enable clears by itself once the command has been handled. Any accepted command write clears the failed bit.
- R4: With no response selected, enable reads 1 for exactly one cycle after the write and then clears. The response words are not touched and no timeout is counted.
- R5: On completion a long-response command loads all four response words (offset 0x10 + 4k gets `eng_resp_i[32k+31:32k]`). A short response loads only word 0 and leaves words 1 to 3 unchanged.
- R6: With timeout value N (offset 0x08) and no completion from the engine, enable clears N+2 cycles after the launching write. Status bit 6 (command timeout) and command bit 14 are then set.
- R7: A completion that carries a CRC7 error sets status bit 4 and command bit 14, captures the response and clears enable.
- R8: A busy-wait command keeps enable set after its response until `eng_busy_end_i` arrives. Status bit 10 (busy interrupt) is then set and enable clears.
- R9: Host status (offset 0x20) bits clear when a one is written to them, and writing 0xFFFF clears every bit. A bit being set in the same cycle as a clear write stays set.
- R10: While enable reads 1, writes to the command and argument words are ignored. The command in flight keeps its fields and argument, and no new start is issued.
- R11: `dat_evt_i` bits 0 to 3 set status bits 3 (FIFO error), 5 (CRC16 error), 7 (data timeout) and 9 (block interrupt) respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address for write and read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| eng_start_o | output | 1 | One-cycle command start to the engine |
| eng_idx_o | output | 6 | Command index |
| eng_flags_o | output | 5 | {busy, no-response, long, write, read} |
| eng_arg_o | output | 32 | Command argument |
| eng_done_i | input | 1 | Engine reports response received |
| eng_crc_err_i | input | 1 | Response had a CRC7 error (valid with done) |
| eng_resp_i | input | 128 | Response bits, word k in bits 32k+31:32k |
| eng_busy_end_i | input | 1 | Card busy period ended |
| dat_evt_i | input | 4 | Data path events: FIFO err, CRC16 err, data timeout, block |

## Verification
The hardest state to reach from the ports is a command held in its busy wait. In that state the response has already arrived, enable is still set, and writes to the command and argument words must bounce. The bench holds the card's busy-end strobe low after the response and issues those writes during the wait. It then checks that the stored fields, the argument and the start strobe are untouched before it releases the busy period. The timeout path is swept over several small counts, and the completion cycle is located by polling the enable bit on every cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned STS_W = 16;

  localparam int unsigned OFF_CMD = 'h00;
  localparam int unsigned OFF_ARG = 'h04;
  localparam int unsigned OFF_TMO = 'h08;
  localparam int unsigned OFF_RSP = 'h10;
  localparam int unsigned OFF_STS = 'h20;

  // command word bits
  localparam int unsigned CB_RD    = 6;
  localparam int unsigned CB_WR    = 7;
  localparam int unsigned CB_LONG  = 9;
  localparam int unsigned CB_NORSP = 10;
  localparam int unsigned CB_BUSY  = 11;
  localparam int unsigned CB_FAIL  = 14;
  localparam int unsigned CB_EN    = 15;

  // status bits
  localparam int unsigned SB_FIFO  = 3;
  localparam int unsigned SB_CRC7  = 4;
  localparam int unsigned SB_CRC16 = 5;
  localparam int unsigned SB_CTMO  = 6;
  localparam int unsigned SB_DTMO  = 7;
  localparam int unsigned SB_BLK   = 9;
  localparam int unsigned SB_BUSY  = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_RSP, ST_WAIT_BUSY} seq_e;

  typedef struct packed {
    logic       busy;
    logic       norsp;
    logic       long_rsp;
    logic       wr;
    logic       rd;
    logic [5:0] idx;
  } cmd_t;
endpackage

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
  import sdc_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             norsp_i,
  input  logic             busy_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             done_i,
  input  logic             crc_err_i,
  input  logic             busy_end_i,
  output logic             start_o,
  output logic             finish_o,
  output logic             cap_o,
  output logic             crc_set_o,
  output logic             tmo_set_o,
  output logic             busy_set_o
);
  seq_e             st_q, st_d;
  logic [TMO_W-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d       = st_q;
    tmr_d      = tmr_q;
    start_o    = 1'b0;
    finish_o   = 1'b0;
    cap_o      = 1'b0;
    crc_set_o  = 1'b0;
    tmo_set_o  = 1'b0;
    busy_set_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          start_o = 1'b1;
          if (norsp_i) begin
            finish_o = 1'b1;
          end else begin
            st_d  = ST_WAIT_RSP;
            tmr_d = tmo_i;
          end
        end
      end
      ST_WAIT_RSP: begin
        if (done_i) begin
          cap_o = 1'b1;
          if (crc_err_i) begin
            crc_set_o = 1'b1;
            finish_o  = 1'b1;
            st_d      = ST_IDLE;
          end else if (busy_i) begin
            st_d = ST_WAIT_BUSY;
          end else begin
            finish_o = 1'b1;
            st_d     = ST_IDLE;
          end
        end else if (tmr_q == '0) begin
          tmo_set_o = 1'b1;
          finish_o  = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_WAIT_BUSY: begin
        if (busy_end_i) begin
          busy_set_o = 1'b1;
          finish_o   = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_TMO_NEEDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_set_o |-> $past(st_d) == ST_WAIT_RSP || $past(start_o)); // R6
endmodule

// File: rtl/sdc_resp_regs.sv
module sdc_resp_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_RESP = 4,
  localparam int unsigned RESP_W = DATA_W * N_RESP
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cap_i,
  input  logic                          long_i,
  input  logic [RESP_W-1:0]             resp_i,
  output logic [N_RESP-1:0][DATA_W-1:0] words_o
);
  for (genvar k = 0; k < N_RESP; k++) begin : g_word
    logic ld;
    if (k == 0) begin : g_lo
      assign ld = cap_i;
    end else begin : g_hi
      assign ld = cap_i && long_i;
      AST_SHORT_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_i && !long_i |=> $stable(words_o[k])); // R5
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  words_o[k] <= '0;
      else if (ld)  words_o[k] <= resp_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sdc_status_reg.sv
module sdc_status_reg
  import sdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;
  end

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) && (set_i == '0) |=> (sts_o & $past(clr_i)) == '0); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (sts_o & $past(set_i)) == $past(set_i)); // R9
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_RESP  = 4,
  parameter int unsigned TMO_W   = 32,
  parameter logic [31:0] TMO_RST = 32'h00F0_0000,
  localparam int unsigned RESP_W = DATA_W * N_RESP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              eng_start_o,
  output logic [5:0]        eng_idx_o,
  output logic [4:0]        eng_flags_o,
  output logic [DATA_W-1:0] eng_arg_o,
  input  logic              eng_done_i,
  input  logic              eng_crc_err_i,
  input  logic [RESP_W-1:0] eng_resp_i,
  input  logic              eng_busy_end_i,
  input  logic [3:0]        dat_evt_i
);
  cmd_t              cmd_q;
  logic              en_q, fail_q;
  logic [DATA_W-1:0] arg_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [STS_W-1:0]  sts, sts_set, sts_clr;
  logic [N_RESP-1:0][DATA_W-1:0] rsp;

  logic wr_cmd, wr_arg, wr_tmo, wr_sts;
  logic finish, cap, crc_set, tmo_set, busy_set;

  assign wr_cmd = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CMD));
  assign wr_arg = bus_we_i && (bus_addr_i == ADDR_W'(OFF_ARG));
  assign wr_tmo = bus_we_i && (bus_addr_i == ADDR_W'(OFF_TMO));
  assign wr_sts = bus_we_i && (bus_addr_i == ADDR_W'(OFF_STS));

  // command word; writes bounce while a command is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      en_q   <= 1'b0;
      fail_q <= 1'b0;
    end else if (wr_cmd && !en_q) begin
      cmd_q.idx      <= bus_wdata_i[5:0];
      cmd_q.rd       <= bus_wdata_i[CB_RD];
      cmd_q.wr       <= bus_wdata_i[CB_WR];
      cmd_q.long_rsp <= bus_wdata_i[CB_LONG];
      cmd_q.norsp    <= bus_wdata_i[CB_NORSP];
      cmd_q.busy     <= bus_wdata_i[CB_BUSY];
      en_q           <= bus_wdata_i[CB_EN];
      fail_q         <= 1'b0;
    end else begin
      if (finish)             en_q   <= 1'b0;
      if (crc_set || tmo_set) fail_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q <= '0;
      tmo_q <= TMO_W'(TMO_RST);
    end else begin
      if (wr_arg && !en_q) arg_q <= bus_wdata_i;
      if (wr_tmo)          tmo_q <= TMO_W'(bus_wdata_i);
    end
  end

  sdc_cmd_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .norsp_i    (cmd_q.norsp),
    .busy_i     (cmd_q.busy),
    .tmo_i      (tmo_q),
    .done_i     (eng_done_i),
    .crc_err_i  (eng_crc_err_i),
    .busy_end_i (eng_busy_end_i),
    .start_o    (eng_start_o),
    .finish_o   (finish),
    .cap_o      (cap),
    .crc_set_o  (crc_set),
    .tmo_set_o  (tmo_set),
    .busy_set_o (busy_set)
  );

  sdc_resp_regs #(.DATA_W(DATA_W), .N_RESP(N_RESP)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .long_i  (cmd_q.long_rsp),
    .resp_i  (eng_resp_i),
    .words_o (rsp)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[SB_FIFO]  = dat_evt_i[0];
    sts_set[SB_CRC16] = dat_evt_i[1];
    sts_set[SB_DTMO]  = dat_evt_i[2];
    sts_set[SB_BLK]   = dat_evt_i[3];
    sts_set[SB_CRC7]  = crc_set;
    sts_set[SB_CTMO]  = tmo_set;
    sts_set[SB_BUSY]  = busy_set;
  end
  assign sts_clr = wr_sts ? bus_wdata_i[STS_W-1:0] : '0;

  sdc_status_reg u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr),
    .sts_o  (sts)
  );

  assign eng_idx_o   = cmd_q.idx;
  assign eng_flags_o = {cmd_q.busy, cmd_q.norsp, cmd_q.long_rsp, cmd_q.wr, cmd_q.rd};
  assign eng_arg_o   = arg_q;

  logic [DATA_W-1:0] cmd_rd;
  always_comb begin
    cmd_rd           = '0;
    cmd_rd[5:0]      = cmd_q.idx;
    cmd_rd[CB_RD]    = cmd_q.rd;
    cmd_rd[CB_WR]    = cmd_q.wr;
    cmd_rd[CB_LONG]  = cmd_q.long_rsp;
    cmd_rd[CB_NORSP] = cmd_q.norsp;
    cmd_rd[CB_BUSY]  = cmd_q.busy;
    cmd_rd[CB_FAIL]  = fail_q;
    cmd_rd[CB_EN]    = en_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFF_CMD)) bus_rdata_o = cmd_rd;
    if (bus_addr_i == ADDR_W'(OFF_ARG)) bus_rdata_o = arg_q;
    if (bus_addr_i == ADDR_W'(OFF_TMO)) bus_rdata_o = DATA_W'(tmo_q);
    if (bus_addr_i == ADDR_W'(OFF_STS)) bus_rdata_o = DATA_W'(sts);
    for (int k = 0; k < N_RESP; k++) begin
      if (bus_addr_i == ADDR_W'(OFF_RSP + 4 * k)) bus_rdata_o = rsp[k];
    end
  end

  AST_NORSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o && cmd_q.norsp |=> !en_q); // R4
  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> sts[SB_CRC7] || sts[SB_CTMO]); // R7
  AST_BUSY_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_set |=> sts[SB_BUSY] && !en_q); // R8
  AST_ARG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && wr_arg |=> $stable(arg_q)); // R10
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && wr_cmd |=> $stable(cmd_q)); // R10
endmodule

// File: tb/tb_sd_cmd_issue.sv
`timescale 1ns/1ps
module tb_sd_cmd_issue;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         start;
  logic [5:0]   idx;
  logic [4:0]   flags;
  logic [31:0]  arg;
  logic         done = 1'b0;
  logic         crc = 1'b0;
  logic [127:0] resp = '0;
  logic         bend = 1'b0;
  logic [3:0]   evt = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  sd_cmd_issue dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .eng_start_o(start),
    .eng_idx_o(idx), .eng_flags_o(flags), .eng_arg_o(arg),
    .eng_done_i(done), .eng_crc_err_i(crc), .eng_resp_i(resp),
    .eng_busy_end_i(bend), .dat_evt_i(evt)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic respond(input logic c, input logic [127:0] r);
    resp = r; crc = c; done = 1'b1;
    @(negedge clk);
    done = 1'b0; crc = 1'b0;
  endtask

  function automatic logic [31:0] fl_bits(input logic [4:0] f);
    return {20'd0, f[4], f[3], f[2], 1'b0, f[1], f[0], 6'd0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0]  v;
    logic [127:0] lr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 cmd", v, 32'h0);
    rd(8'h04, v); chk("R1 arg", v, 32'h0);
    rd(8'h08, v); chk("R1 tmo", v, 32'h00F0_0000);
    rd(8'h20, v); chk("R1 sts", v, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h10 + 4 * k), v); chk("R1 rsp", v, 32'h0);
    end

    // R2 field layout sweep, no launch
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      d = 32'(i) | fl_bits(5'(i)) | 32'h7100;
      @(negedge clk);
      wr(8'h00, d);
      chk("R2 start idle", {31'd0, start}, 32'd0);
      rd(8'h00, v); chk("R2 fields", v, d & 32'h0EFF);
    end

    // R2/R3/R5 short launches
    for (int i = 0; i < 3; i++) begin
      logic [5:0]  ix;
      logic [4:0]  f;
      logic [31:0] w;
      ix = 6'(17 + 19 * i);
      f  = 5'(i + 1) & 5'b00011;
      w  = 32'hC0DE_0000 + 32'(i * 7);
      @(negedge clk);
      wr(8'h04, 32'hA5A5_0000 + 32'(i));
      wr(8'h00, 32'h8000 | fl_bits(f) | 32'(ix));
      chk("R2 start", {31'd0, start}, 32'd1);
      chk("R2 idx", {26'd0, idx}, {26'd0, ix});
      chk("R2 flags", {27'd0, flags}, {27'd0, f});
      chk("R2 arg", arg, 32'hA5A5_0000 + 32'(i));
      @(negedge clk);
      chk("R2 start one cycle", {31'd0, start}, 32'd0);
      rd(8'h00, v); chk("R3 en held", v, 32'h8000 | fl_bits(f) | 32'(ix));
      respond(1'b0, {96'd0, w});
      rd(8'h00, v); chk("R3 en cleared", v, fl_bits(f) | 32'(ix));
      rd(8'h10, v); chk("R5 short w0", v, w);
    end

    // R5 long response then short keeps upper words
    lr = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0BAD_F00D};
    @(negedge clk);
    wr(8'h00, 32'h8000 | fl_bits(5'b00100) | 32'd2);
    chk("R2 long flag", {27'd0, flags}, 32'd4);
    @(negedge clk);
    respond(1'b0, lr);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h10 + 4 * k), v); chk("R5 long word", v, lr[32*k +: 32]);
    end
    wr(8'h00, 32'h8000 | 32'd13);
    @(negedge clk);
    respond(1'b0, {32'hFFFF_FFFF, 32'hEEEE_EEEE, 32'hDDDD_DDDD, 32'h5555_AAAA});
    rd(8'h10, v); chk("R5 short after long w0", v, 32'h5555_AAAA);
    for (int k = 1; k < 4; k++) begin
      rd(8'(8'h10 + 4 * k), v); chk("R5 upper kept", v, lr[32*k +: 32]);
    end

    // R4 no response
    @(negedge clk);
    wr(8'h00, 32'h8000 | fl_bits(5'b01000));
    chk("R4 start", {31'd0, start}, 32'd1);
    rd(8'h00, v); chk("R4 en one cycle", v, 32'h8400);
    @(negedge clk);
    rd(8'h00, v); chk("R4 en cleared", v, 32'h0400);
    respond(1'b0, {96'd0, 32'h7777_7777});
    rd(8'h10, v); chk("R4 no capture", v, 32'h5555_AAAA);
    rd(8'h20, v); chk("R4 no timeout", v, 32'h0);

    // R6 timeout sweep
    for (int n = 0; n < 6; n++) begin
      int c;
      @(negedge clk);
      wr(8'h08, 32'(n));
      wr(8'h00, 32'h8000 | 32'd5);
      c = 0;
      forever begin
        rd(8'h00, v);
        if (!v[15] || c > 50) break;
        @(negedge clk);
        c++;
      end
      chk("R6 latency", 32'(c), 32'(n + 2));
      rd(8'h00, v); chk("R6 failed bit", v, 32'h4005);
      rd(8'h20, v); chk("R6 cmd timeout sts", v, 32'h0040);
      wr(8'h20, 32'h0040);
      rd(8'h20, v); chk("R9 w1c bit6", v, 32'h0);
    end
    wr(8'h08, 32'd100);

    // R7 CRC7 error, then R3 failed cleared by next command write
    @(negedge clk);
    wr(8'h00, 32'h8000 | 32'd51);
    @(negedge clk);
    respond(1'b1, {96'd0, 32'h0C0C_0C0C});
    rd(8'h00, v); chk("R7 failed", v, 32'h4000 | 32'd51);
    rd(8'h20, v); chk("R7 crc7 sts", v, 32'h0010);
    rd(8'h10, v); chk("R7 captured", v, 32'h0C0C_0C0C);
    wr(8'h00, 32'h8000 | fl_bits(5'b01000));
    @(negedge clk);
    rd(8'h00, v); chk("R3 failed cleared", v, 32'h0400);
    wr(8'h20, 32'hFFFF);

    // R8 busy wait with R10 ignored writes
    @(negedge clk);
    wr(8'h04, 32'h0000_1234);
    wr(8'h00, 32'h8000 | fl_bits(5'b10000) | 32'd12);
    @(negedge clk);
    respond(1'b0, {96'd0, 32'h0000_0900});
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R8 en during busy", v, 32'h8000 | fl_bits(5'b10000) | 32'd12);
    rd(8'h20, v); chk("R8 no int yet", v, 32'h0);
    wr(8'h00, 32'h8000 | 32'd21);
    chk("R10 no start", {31'd0, start}, 32'd0);
    wr(8'h04, 32'h1234_5678);
    rd(8'h00, v); chk("R10 cmd kept", v, 32'h8000 | fl_bits(5'b10000) | 32'd12);
    rd(8'h04, v); chk("R10 arg kept", v, 32'h0000_1234);
    bend = 1'b1;
    @(negedge clk);
    bend = 1'b0;
    rd(8'h00, v); chk("R8 en cleared", v, fl_bits(5'b10000) | 32'd12);
    rd(8'h20, v); chk("R8 busy int", v, 32'h0400);

    // R9/R11 status events and clears
    wr(8'h20, 32'hFFFF);
    rd(8'h20, v); chk("R9 clear all", v, 32'h0);
    evt = 4'b1111;
    @(negedge clk);
    evt = 4'b0000;
    rd(8'h20, v); chk("R11 events", v, 32'h02A8);
    wr(8'h20, 32'h0028);
    rd(8'h20, v); chk("R9 partial clear", v, 32'h0280);
    evt = 4'b0001;
    wr(8'h20, 32'h0008);
    evt = 4'b0000;
    rd(8'h20, v); chk("R9 set wins", v, 32'h0288);
    wr(8'h20, 32'hFFFF);
    rd(8'h20, v); chk("R9 clear all again", v, 32'h0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule